// File: doc/BRIEF.md
# Capture/Compare Timer with Periodic Interrupt

This block is a general-purpose timing unit built around a free-running counter that software can read but never load. Three capture channels snapshot the counter when a chosen transition appears on their input pins, and five compare channels watch the counter for a programmed value. On a match, a compare channel applies an automatic action to its own output pin. A periodic tick drawn from a separate divider chain gives a steady interrupt at one of four selectable rates. The counter's wrap from its top value back to zero is also flagged.

Every event source has a flag bit and an enable bit. A single interrupt request line is raised while any enabled flag is set. Software reaches the block through a small register port with a combinational read path. Writes take effect on the next clock edge.

The block has no sequencer of its own. Its behaviour is set by two enumerated mode sets. Each capture channel is in one of four edge modes: OFF, RISE, FALL or ANY. Each compare channel is in one of four pin actions: NONE, TOGGLE, LOW or HIGH. A mode changes only when software writes a new value, and takes effect from the next edge.

Top module: `capcmp_timer`

## Requirements
- R1: Reset clears the counter to 0. After reset the counter increases by one every clock and wraps modulo 2^CNT_W. A write to address 0 (the counter) has no effect on it.
- R2: The overflow flag (flag bit N_CMP+N_CAP, bit 8 by default) sets on the clock edge where the counter wraps from its top value to 0.
- R3: Each capture pin passes through a two-stage synchroniser. Its 2-bit edge mode sits at bits [2i+1:2i] of the edge register, at address 1+N_CAP+N_CMP (9 by default). The codes are 00 = OFF, 01 = RISE, 10 = FALL, 11 = ANY. When a selected transition occurs, the latch stores the counter value as it stood two clocks after the pin changed. Unselected transitions leave the latch unchanged.
- R4: A capture event sets flag bit N_CMP+i (bits 5..7 by default) on the same edge that loads latch i.
- R5: Compare register i sits at address 1+N_CAP+i (4..8 by default) and is CNT_W bits wide. Flag bit i sets on the edge that follows the cycle in which the counter equals the compare register.
- R6: The pin action of compare channel i sits at bits [2i+1:2i] of the action register, at address 10 by default. On a match the codes do the following: 00 leaves the pin unchanged, 01 toggles it, 10 drives it low and 11 drives it high. The output enable of channel i is high exactly when its action code is nonzero.
- R7: The periodic flag (the top flag bit, bit 9 by default) sets every 2^(RTI_BASE+s) clocks, on edges where the divider chain's low RTI_BASE+s bits become zero. The chain starts from 0 at reset in step with the counter. The rate select s is the 2-bit register at address 13.
- R8: Writing to the flag register (address 12) clears each flag whose written bit is 1. Bits written as 0 leave their flags unchanged. A new event in the same cycle as a clear keeps its flag set.
- R9: `irq` is high exactly when some flag is set whose enable bit is also set. The enable register sits at address 11 and uses the flag layout.
- R10: Register reads return only the implemented bits, with all other bits 0. Capture latches are read-only at addresses 1..N_CAP. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| cap_pin | input | N_CAP | Capture input pins |
| cmp_pin | output | N_CMP | Compare output pins |
| cmp_oe | output | N_CMP | Compare pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench shrinks the counter to CNT_W = 8 and the periodic divider base to RTI_BASE = 2. It keeps three capture channels, five compare channels and a 16-bit data bus. The 8-bit counter makes wraps every 256 clocks, so both the overflow flag and the counter's own wrap can be observed within a short run. The small divider base brings all four periodic rates (4, 8, 16 and 32 clocks) into reach, and each rate is checked for both the absence and the arrival of its tick. The narrow counter also shows that compare registers truncate wide writes.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } pin_act_e;

endpackage

// File: rtl/capcmp_capture.sv
module capcmp_capture
    import capcmp_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  edge_sel_e        mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] latch_o
);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              level;
    logic              rise;
    logic              fall;
    logic [CNT_W-1:0]  latch_q;

    assign level = sync_q[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin_i};
            prev_q <= level;
        end
    end

    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        unique case (mode_i)
            EDGE_OFF:  hit_o = 1'b0;
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            EDGE_ANY:  hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (hit_o) begin
            latch_q <= cnt_i;
        end
    end

    assign latch_o = latch_q;

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_o) |-> latch_o == $past(cnt_i)); // R3

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hit_o) |-> $stable(latch_o)); // R3

endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare
    import capcmp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  pin_act_e         act_i,
    output logic [CNT_W-1:0] value_o,
    output logic             hit_o,
    output logic             pin_o,
    output logic             oe_o
);

    logic [CNT_W-1:0] value_q;
    logic             pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (we_i) begin
            value_q <= wdata_i;
        end
    end

    assign hit_o = (cnt_i == value_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (hit_o) begin
            unique case (act_i)
                ACT_NONE:   pin_q <= pin_q;
                ACT_TOGGLE: pin_q <= ~pin_q;
                ACT_LOW:    pin_q <= 1'b0;
                ACT_HIGH:   pin_q <= 1'b1;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    assign value_o = value_q;
    assign pin_o   = pin_q;
    assign oe_o    = (act_i != ACT_NONE);

    AST_CMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_o && act_i == ACT_HIGH) |-> pin_o); // R6

    AST_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_o && act_i == ACT_LOW) |-> !pin_o); // R6

    AST_CMP_IDLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hit_o) |-> $stable(pin_o)); // R6

endmodule

// File: rtl/capcmp_rti.sv
module capcmp_rti #(
    parameter int unsigned BASE   = 13,
    parameter int unsigned RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);

    localparam int unsigned CHAIN_W = BASE + (1 << RATE_W) - 1;

    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W:0]   span;
    logic [CHAIN_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_q + 1'b1;
        end
    end

    always_comb begin
        span   = (CHAIN_W + 1)'(1) << (BASE + 32'(rate_i));
        mask   = CHAIN_W'(span - 1'b1);
        tick_o = ((chain_q & mask) == mask);
    end

    AST_RTI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R7

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned N_CAP    = 3,
    parameter int unsigned N_CMP    = 5,
    parameter int unsigned RTI_BASE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CAP-1:0]  cap_pin,
    output logic [N_CMP-1:0]  cmp_pin,
    output logic [N_CMP-1:0]  cmp_oe,
    output logic              irq
);

    localparam int unsigned N_FLAG  = N_CMP + N_CAP + 2;
    localparam int unsigned FL_CAP0 = N_CMP;
    localparam int unsigned FL_OVF  = N_CMP + N_CAP;
    localparam int unsigned FL_RTI  = FL_OVF + 1;
    localparam int unsigned A_COUNT = 0;
    localparam int unsigned A_CAP0  = 1;
    localparam int unsigned A_CMP0  = A_CAP0 + N_CAP;
    localparam int unsigned A_EDGE  = A_CMP0 + N_CMP;
    localparam int unsigned A_ACT   = A_EDGE + 1;
    localparam int unsigned A_IEN   = A_ACT + 1;
    localparam int unsigned A_FLAG  = A_IEN + 1;
    localparam int unsigned A_RATE  = A_FLAG + 1;
    localparam int unsigned RATE_W  = 2;

    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    edge_sel_e         edge_q   [N_CAP];
    pin_act_e          act_q    [N_CMP];
    logic [N_FLAG-1:0] ien_q;
    logic [N_FLAG-1:0] flag_q;
    logic [RATE_W-1:0] rate_q;

    logic [N_CAP-1:0]  cap_hit;
    logic [CNT_W-1:0]  cap_latch [N_CAP];
    logic [N_CMP-1:0]  cmp_hit;
    logic [N_CMP-1:0]  cmp_we;
    logic [CNT_W-1:0]  cmp_val   [N_CMP];
    logic              rti_tick;
    logic              cnt_wrap;
    logic              wr_edge, wr_act, wr_ien, wr_flag, wr_rate;
    logic [N_FLAG-1:0] flag_set;
    logic [N_FLAG-1:0] flag_clr;

    // Free-running counter (no write path)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            run_q <= 1'b1;
        end
    end

    assign cnt_wrap = &cnt_q;

    // Register write decode
    always_comb begin
        wr_edge = bus_wr && (bus_addr == ADDR_W'(A_EDGE));
        wr_act  = bus_wr && (bus_addr == ADDR_W'(A_ACT));
        wr_ien  = bus_wr && (bus_addr == ADDR_W'(A_IEN));
        wr_flag = bus_wr && (bus_addr == ADDR_W'(A_FLAG));
        wr_rate = bus_wr && (bus_addr == ADDR_W'(A_RATE));
        for (int i = 0; i < N_CMP; i++) begin
            cmp_we[i] = bus_wr && (bus_addr == ADDR_W'(A_CMP0 + i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CAP; i++) edge_q[i] <= EDGE_OFF;
            for (int i = 0; i < N_CMP; i++) act_q[i] <= ACT_NONE;
            ien_q  <= '0;
            rate_q <= '0;
        end else begin
            if (wr_edge) begin
                for (int i = 0; i < N_CAP; i++) edge_q[i] <= edge_sel_e'(bus_wdata[2*i +: 2]);
            end
            if (wr_act) begin
                for (int i = 0; i < N_CMP; i++) act_q[i] <= pin_act_e'(bus_wdata[2*i +: 2]);
            end
            if (wr_ien)  ien_q  <= bus_wdata[N_FLAG-1:0];
            if (wr_rate) rate_q <= bus_wdata[RATE_W-1:0];
        end
    end

    // Flags: event set wins over write-one clear
    always_comb begin
        flag_set = {rti_tick, cnt_wrap, cap_hit, cmp_hit};
        flag_clr = wr_flag ? bus_wdata[N_FLAG-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    assign irq = |(flag_q & ien_q);

    // Channels
    for (genvar gc = 0; gc < N_CAP; gc++) begin : g_cap
        capcmp_capture #(
            .CNT_W (CNT_W),
            .SYNC_N(2)
        ) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (cap_pin[gc]),
            .mode_i (edge_q[gc]),
            .cnt_i  (cnt_q),
            .hit_o  (cap_hit[gc]),
            .latch_o(cap_latch[gc])
        );
    end

    for (genvar gm = 0; gm < N_CMP; gm++) begin : g_cmp
        capcmp_compare #(
            .CNT_W(CNT_W)
        ) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_i  (cnt_q),
            .we_i   (cmp_we[gm]),
            .wdata_i(bus_wdata[CNT_W-1:0]),
            .act_i  (act_q[gm]),
            .value_o(cmp_val[gm]),
            .hit_o  (cmp_hit[gm]),
            .pin_o  (cmp_pin[gm]),
            .oe_o   (cmp_oe[gm])
        );
    end

    capcmp_rti #(
        .BASE  (RTI_BASE),
        .RATE_W(RATE_W)
    ) u_rti (
        .clk   (clk),
        .rst_n (rst_n),
        .rate_i(rate_q),
        .tick_o(rti_tick)
    );

    // Read path
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_COUNT)) bus_rdata = DATA_W'(cnt_q);
        for (int i = 0; i < N_CAP; i++) begin
            if (bus_addr == ADDR_W'(A_CAP0 + i)) bus_rdata = DATA_W'(cap_latch[i]);
        end
        for (int i = 0; i < N_CMP; i++) begin
            if (bus_addr == ADDR_W'(A_CMP0 + i)) bus_rdata = DATA_W'(cmp_val[i]);
        end
        if (bus_addr == ADDR_W'(A_EDGE)) begin
            for (int i = 0; i < N_CAP; i++) bus_rdata[2*i +: 2] = edge_q[i];
        end
        if (bus_addr == ADDR_W'(A_ACT)) begin
            for (int i = 0; i < N_CMP; i++) bus_rdata[2*i +: 2] = act_q[i];
        end
        if (bus_addr == ADDR_W'(A_IEN))  bus_rdata = DATA_W'(ien_q);
        if (bus_addr == ADDR_W'(A_FLAG)) bus_rdata = DATA_W'(flag_q);
        if (bus_addr == ADDR_W'(A_RATE)) bus_rdata = DATA_W'(rate_q);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == '0) |-> flag_q[FL_OVF]); // R2

    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(wr_flag && bus_wdata[FL_OVF] && !cnt_wrap)) |-> !flag_q[FL_OVF]); // R8

    AST_RTI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rti_tick) |-> flag_q[FL_RTI]); // R7

    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_hit[0]) |-> flag_q[FL_CAP0]); // R4

endmodule

// File: tb/capcmp_timer_tb.sv
module capcmp_timer_tb;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;
    localparam int N_CAP  = 3;
    localparam int N_CMP  = 5;
    localparam int BASE   = 2;
    localparam int A_EDGE = 9;
    localparam int A_ACT  = 10;
    localparam int A_IEN  = 11;
    localparam int A_FLAG = 12;
    localparam int A_RATE = 13;
    localparam int FL_OVF = 8;
    localparam int FL_RTI = 9;
    localparam int N_VEC  = 9;

    // {addr, write data, expected read-back}
    localparam logic [35:0] VEC [N_VEC] = '{
        {4'd4,  16'h1234, 16'h0034},
        {4'd5,  16'hABCD, 16'h00CD},
        {4'd8,  16'hFFFF, 16'h00FF},
        {4'd9,  16'hFFFF, 16'h003F},
        {4'd10, 16'hFFFF, 16'h03FF},
        {4'd11, 16'hFFFF, 16'h03FF},
        {4'd13, 16'hFFFF, 16'h0003},
        {4'd14, 16'hFFFF, 16'h0000},
        {4'd2,  16'hFFFF, 16'h0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [N_CAP-1:0]  cap_pin = '0;
    logic [N_CMP-1:0]  cmp_pin;
    logic [N_CMP-1:0]  cmp_oe;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    int cap_m [N_CAP];
    int pin_m [N_CMP];

    always #5 clk = ~clk;

    capcmp_timer #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(4),
        .N_CAP(N_CAP), .N_CMP(N_CMP), .RTI_BASE(BASE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
        .cmp_pin(cmp_pin), .cmp_oe(cmp_oe), .irq(irq)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", tag, got, got, exp, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic wr(input int a, input int d);
        bus_addr  = 4'(a);
        bus_wdata = 16'(d);
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 4'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic flag_bit(input int b, output int v);
        int f;
        rd(A_FLAG, f);
        v = (f >> b) & 1;
    endtask

    task automatic wait_mod(input int p, input int r);
        int v;
        rd(0, v);
        while ((v % p) != r) begin
            @(negedge clk);
            rd(0, v);
        end
    endtask

    task automatic do_reset();
        int v;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rd(0, v);      chk("R1 counter in reset", v, 0);
        rd(A_FLAG, v); chk("R8 flags in reset", v, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, v);      chk("R1 first count after reset", v, 1);
        for (int i = 0; i < N_CAP; i++) cap_m[i] = 0;
        for (int i = 0; i < N_CMP; i++) pin_m[i] = 0;
    endtask

    task automatic cmp_run(input int ch, input int act);
        int c, v, exp_pin;
        wr(A_ACT, act << (2 * ch));
        rd(0, c);
        wr(4 + ch, (c + 10) % 256);
        wr(A_FLAG, 1 << ch);
        repeat (8) @(negedge clk);
        chk("R6 pin before match", int'(cmp_pin[ch]), pin_m[ch]);
        flag_bit(ch, v); chk("R5 flag before match", v, 0);
        @(negedge clk);
        case (act)
            1: exp_pin = 1 - pin_m[ch];
            2: exp_pin = 0;
            3: exp_pin = 1;
            default: exp_pin = pin_m[ch];
        endcase
        pin_m[ch] = exp_pin;
        chk("R6 pin after match", int'(cmp_pin[ch]), exp_pin);
        chk("R6 output enable", int'(cmp_oe[ch]), (act != 0) ? 1 : 0);
        flag_bit(ch, v); chk("R5 flag after match", v, 1);
    endtask

    task automatic cap_run(input int ch, input int mode, input logic lvl, input int hit);
        int c, v, exp_lat;
        wr(A_EDGE, mode << (2 * ch));
        wr(A_FLAG, 1 << (N_CMP + ch));
        rd(0, c);
        cap_pin[ch] = lvl;
        repeat (2) @(negedge clk);
        flag_bit(N_CMP + ch, v); chk("R4 capture flag not early", v, 0);
        @(negedge clk);
        exp_lat = hit ? (c + 2) % 256 : cap_m[ch];
        cap_m[ch] = exp_lat;
        rd(1 + ch, v);           chk("R3 capture latch", v, exp_lat);
        flag_bit(N_CMP + ch, v); chk("R4 capture flag", v, hit);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        int v, p;
        do_reset();

        // R1: writes to the counter are ignored
        rd(0, v);
        p = v;
        wr(0, 16'h0055);
        rd(0, v); chk("R1 counter write ignored", v, (p + 1) % 256);

        // R10: register table
        for (int i = 0; i < N_VEC; i++) begin
            wr(int'(VEC[i][35:32]), int'(VEC[i][31:16]));
            rd(int'(VEC[i][35:32]), v);
            chk("R10 register read-back", v, int'(VEC[i][15:0]));
        end

        do_reset();

        // R5 R6 compare actions
        cmp_run(2, 3);
        // R9 interrupt combining on compare flag 2
        chk("R9 irq with no enables", int'(irq), 0);
        wr(A_IEN, 1 << 2);
        chk("R9 irq raised", int'(irq), 1);
        wr(A_FLAG, 0);
        flag_bit(2, v); chk("R8 zero write keeps flag", v, 1);
        wr(A_FLAG, 1 << 2);
        flag_bit(2, v); chk("R8 one write clears flag", v, 0);
        chk("R9 irq dropped", int'(irq), 0);
        wr(A_IEN, 0);
        cmp_run(2, 2);
        cmp_run(2, 1);
        cmp_run(2, 1);
        cmp_run(2, 0);
        cmp_run(0, 3);
        cmp_run(4, 1);

        // R3 R4 capture edge modes
        cap_run(1, 1, 1'b1, 1);
        cap_run(1, 1, 1'b0, 0);
        cap_run(1, 2, 1'b1, 0);
        cap_run(1, 2, 1'b0, 1);
        cap_run(1, 3, 1'b1, 1);
        cap_run(1, 3, 1'b0, 1);
        cap_run(1, 0, 1'b1, 0);
        cap_run(1, 0, 1'b0, 0);
        cap_run(0, 1, 1'b1, 1);
        cap_run(2, 3, 1'b1, 1);

        // R2 overflow
        wait_mod(256, 250);
        wr(A_FLAG, 1 << FL_OVF);
        wait_mod(256, 255);
        flag_bit(FL_OVF, v); chk("R2 no overflow before wrap", v, 0);
        @(negedge clk);
        rd(0, v);            chk("R1 counter wraps to 0", v, 0);
        flag_bit(FL_OVF, v); chk("R2 overflow on wrap", v, 1);

        // R7 periodic rates
        for (int s = 0; s < 4; s++) begin
            p = (1 << BASE) << s;
            wr(A_RATE, s);
            wait_mod(p, 1);
            wr(A_FLAG, 1 << FL_RTI);
            wait_mod(p, p - 1);
            flag_bit(FL_RTI, v); chk("R7 no tick inside period", v, 0);
            @(negedge clk);
            flag_bit(FL_RTI, v); chk("R7 tick at period boundary", v, 1);
        end

        summary();
        $finish;
    end

endmodule